// File: doc/BRIEF.md
# Randomized Multi-Phase Strobe Generator

This block makes the instants at which a protected datapath's register groups capture data unpredictable from one system period to the next, so that the power trace no longer lines up with the data being processed. A fast reference clock drives a period counter. Each system period lasts `PERIOD` fast cycles. Within each period the block offers `N_PHASES` evenly spaced capture points, `STEP` fast cycles apart, so the latest one lags the first by `(N_PHASES-1)*STEP`.

Each of the `NUM_OUT` outputs is a one-fast-cycle strobe, to be used as a clock enable by one register group. Once per period, and separately for each output, a built-in 32-bit LFSR picks which of the capture points that output follows. A new pick is applied only in the last cycle of the period. No capture point falls in that cycle, so no strobe is ever cut short or doubled.

The period must be longer than the largest lag plus one strobe. That way data launched at any phase settles before the next capture. The current picks are driven out with the strobes.

Top module: `rpc_strobe_gen`

## Requirements
- R1: In the cycle after a synchronous reset, all strobes are low, every phase index in `phase_sel` is 0 and the LFSR holds the default seed 0xACE12469.
- R2: While `enable` was low at the previous edge, all strobes are low. The first period position (0) is the cycle after the edge that samples `enable` high.
- R3: While enabled, a period lasts `PERIOD` cycles at positions 0 to `PERIOD-1`. Each output gives exactly one single-cycle strobe per period, and never at position `PERIOD-1`.
- R4: Output i strobes in the cycle whose period position equals `sel_i*STEP`, where `sel_i` is the index shown for output i in that cycle.
- R5: `phase_sel` changes only in the cycle after a reset or after the last position (`PERIOD-1`) of an enabled period.
- R6: At that last position, `sel_i` takes bits `[i*SELW +: SELW]` of the current LFSR state and the LFSR advances once by the Galois rule `s' = (s>>1) ^ (s[0] ? 0x80200003 : 0)`. Output i is shown at bits `[i*SELW +: SELW]` of `phase_sel`, where `SELW = log2(N_PHASES)`.
- R7: With `seed_load` high at an edge, the LFSR takes `seed_val` at that edge, or the default seed if `seed_val` is zero. A load takes precedence over an advance. The current selections and the period position are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast reference clock; one cycle is the phase unit |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the period counter and strobes |
| seed_load | input | 1 | Load `seed_val` into the LFSR |
| seed_val | input | 32 | Seed value; zero selects the default seed |
| strobe | output | NUM_OUT | One-cycle capture strobe per register group |
| phase_sel | output | NUM_OUT*SELW | Current phase index of each output |

## Verification
A strobe is due in the same cycle the period counter holds the matching position. The counter starts at position 0 one cycle after `enable` is sampled high. A new selection is due one cycle after the edge at position `PERIOD-1`. A seed load shows up only in the selections drawn at the next period end. The bench advances its behavioural model on each rising edge using the inputs it drove half a cycle earlier. It compares `strobe` and `phase_sel` on the following falling edge, so each comparison sees exactly the registers updated by that one edge. Stimulus covers enable gaps inside a period, seed loads (including zero and a load held across a period end) and a reset during operation.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    localparam int LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003;

    typedef logic [LFSR_W-1:0] lfsr_t;

    // Status of the period counter, shared by all phase slots
    typedef struct packed {
        logic run;   // counter active this cycle
        logic wrap;  // last position of an active period: safe window
    } period_ev_t;

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction

    function automatic lfsr_t seed_fix(input lfsr_t s, input lfsr_t dflt);
        return (s == '0) ? dflt : s;
    endfunction

endpackage

// File: rtl/rpc_period_ctr.sv
module rpc_period_ctr
    import rpc_pkg::*;
#(
    parameter int PERIOD = 24,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    output logic [CW-1:0] pos,
    output period_ev_t    ev
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic          run_q;
    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pos_q <= '0;
        end else begin
            run_q <= enable;
            if (!run_q || pos_q == LAST)
                pos_q <= '0;
            else
                pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        ev.run  = run_q;
        ev.wrap = run_q && (pos_q == LAST);
    end

    assign pos = pos_q;

endmodule

// File: rtl/rpc_lfsr.sv
module rpc_lfsr
    import rpc_pkg::*;
#(
    parameter lfsr_t SEED_DEF = 32'hACE1_2469
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  lfsr_t seed,
    input  logic  advance,
    output lfsr_t state
);

    lfsr_t st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= SEED_DEF;
        else if (load)
            st_q <= seed_fix(seed, SEED_DEF);
        else if (advance)
            st_q <= lfsr_step(st_q);
    end

    assign state = st_q;

endmodule

// File: rtl/rpc_phase_slot.sv
module rpc_phase_slot
    import rpc_pkg::*;
#(
    parameter int SELW = 4,
    parameter int CW   = 5,
    parameter int STEP = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  period_ev_t      ev,
    input  logic [CW-1:0]   pos,
    input  logic [SELW-1:0] draw,
    output logic [SELW-1:0] sel,
    output logic            strobe
);

    logic [SELW-1:0] sel_q;
    logic [CW-1:0]   off;

    // Selection may only move in the safe window at the end of a period
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (ev.wrap)
            sel_q <= draw;
    end

    always_comb begin
        off    = CW'(int'(sel_q) * STEP);
        strobe = ev.run && (pos == off);
    end

    assign sel = sel_q;

endmodule

// File: rtl/rpc_strobe_gen.sv
module rpc_strobe_gen
    import rpc_pkg::*;
#(
    parameter int    NUM_OUT  = 8,
    parameter int    N_PHASES = 16,
    parameter int    STEP     = 1,
    parameter int    PERIOD   = 24,
    parameter lfsr_t SEED_DEF = 32'hACE1_2469,
    localparam int   SELW     = $clog2(N_PHASES),
    localparam int   CW       = $clog2(PERIOD)
) (
    input  logic                     clk_fast,
    input  logic                     rst,
    input  logic                     enable,
    input  logic                     seed_load,
    input  logic [31:0]              seed_val,
    output logic [NUM_OUT-1:0]       strobe,
    output logic [NUM_OUT*SELW-1:0]  phase_sel
);

    // Parameter sanity, checked at elaboration
    if ((1 << SELW) != N_PHASES) begin : g_bad_phases
        $error("N_PHASES must be a power of two");
    end
    if (NUM_OUT * SELW > LFSR_W) begin : g_bad_width
        $error("NUM_OUT*SELW exceeds the LFSR width");
    end
    if ((N_PHASES - 1) * STEP > PERIOD - 2) begin : g_bad_period
        $error("PERIOD must exceed the largest lag plus one strobe");
    end

    period_ev_t    pev;
    logic [CW-1:0] pos_q;
    lfsr_t         lfsr_q;
    logic          run_w;

    rpc_period_ctr #(.PERIOD(PERIOD)) u_ctr (
        .clk    (clk_fast),
        .rst    (rst),
        .enable (enable),
        .pos    (pos_q),
        .ev     (pev)
    );

    rpc_lfsr #(.SEED_DEF(SEED_DEF)) u_lfsr (
        .clk     (clk_fast),
        .rst     (rst),
        .load    (seed_load),
        .seed    (seed_val),
        .advance (pev.wrap),
        .state   (lfsr_q)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
        rpc_phase_slot #(
            .SELW (SELW),
            .CW   (CW),
            .STEP (STEP)
        ) u_slot (
            .clk    (clk_fast),
            .rst    (rst),
            .ev     (pev),
            .pos    (pos_q),
            .draw   (lfsr_q[i*SELW +: SELW]),
            .sel    (phase_sel[i*SELW +: SELW]),
            .strobe (strobe[i])
        );
    end

    assign run_w = pev.run;

endmodule

// File: rtl/rpc_strobe_chk.sv
module rpc_strobe_chk #(
    parameter int NUM_OUT = 8,
    parameter int SELW    = 4,
    parameter int CW      = 5,
    parameter int PERIOD  = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    run,
    input logic [CW-1:0]           pos,
    input logic [31:0]             lfsr,
    input logic [NUM_OUT-1:0]      strobe,
    input logic [NUM_OUT*SELW-1:0] phase_sel
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_sel == '0 && strobe == '0));

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !run |-> strobe == '0);

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (run && pos == LAST) |=> pos == '0);

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(run && pos == LAST) |=> $stable(phase_sel));

    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);

    // R3: one strobe per output per period, counted per output
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cnt
        logic [1:0] hits;
        always_ff @(posedge clk) begin
            if (rst || !run || pos == LAST)
                hits <= '0;
            else if (strobe[i] && hits != 2'd3)
                hits <= hits + 2'd1;
            if (!rst && run && pos == LAST)
                p_one_per_period_r3: assert (hits == 2'd1 && !strobe[i]);
        end
    end

endmodule

bind rpc_strobe_gen rpc_strobe_chk #(
    .NUM_OUT (NUM_OUT),
    .SELW    (SELW),
    .CW      (CW),
    .PERIOD  (PERIOD)
) u_chk (
    .clk       (clk_fast),
    .rst       (rst),
    .run       (run_w),
    .pos       (pos_q),
    .lfsr      (lfsr_q),
    .strobe    (strobe),
    .phase_sel (phase_sel)
);

// File: tb/sim_rpc_strobe_gen.sv
module sim_rpc_strobe_gen;

    localparam int NO = 8;
    localparam int NP = 16;
    localparam int ST = 1;
    localparam int PR = 24;
    localparam int SW = 4;
    localparam bit [31:0] SD = 32'hACE1_2469;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic              seed_load = 1'b0;
    logic [31:0]       seed_val = '0;
    logic [NO-1:0]     strobe;
    logic [NO*SW-1:0]  phase_sel;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    rpc_strobe_gen #(
        .NUM_OUT (NO), .N_PHASES (NP), .STEP (ST), .PERIOD (PR), .SEED_DEF (SD)
    ) u0 (
        .clk_fast  (clk),
        .rst       (rst),
        .enable    (enable),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .strobe    (strobe),
        .phase_sel (phase_sel)
    );

    // Behavioural reference model
    bit        m_run = 0;
    int        m_pos = 0;
    int        m_sel [NO];
    bit [31:0] m_lfsr = SD;
    bit        m_may = 1;
    bit        live = 0;
    string     sel_tag = "R6";
    logic [NO*SW-1:0] prev_p;
    int        hits [NO];

    function automatic bit [31:0] nxt(input bit [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    always @(posedge clk) begin
        bit [31:0] old;
        bit        adv;
        if (rst) begin
            m_run = 0; m_pos = 0; m_lfsr = SD; m_may = 1;
            foreach (m_sel[i]) m_sel[i] = 0;
            live = 1;
        end else begin
            old = m_lfsr;
            adv = m_run && (m_pos == PR - 1);
            if (seed_load) m_lfsr = (seed_val == 0) ? SD : seed_val;
            else if (adv)  m_lfsr = nxt(old);
            if (adv)
                foreach (m_sel[i]) m_sel[i] = int'((old >> (i * SW)) & (NP - 1));
            m_pos = (!m_run || m_pos == PR - 1) ? 0 : m_pos + 1;
            m_run = enable;
            m_may = adv;
        end
    end

    always @(negedge clk) begin
        logic [NO-1:0]    exp_s;
        logic [NO*SW-1:0] exp_p;
        if (live) begin
            for (int i = 0; i < NO; i++) begin
                exp_s[i] = m_run && (m_pos == m_sel[i] * ST);
                exp_p[i*SW +: SW] = SW'(m_sel[i]);
            end
            compared++;
            if (strobe !== exp_s) begin
                mismatched++;
                $display("FAIL %s strobe pos=%0d got %h exp %h",
                         m_run ? "R4" : "R2", m_pos, strobe, exp_s);
            end
            compared++;
            if (phase_sel !== exp_p) begin
                mismatched++;
                $display("FAIL %s phase_sel got %h exp %h", sel_tag, phase_sel, exp_p);
            end
            compared++;
            if (!m_may && phase_sel !== prev_p) begin
                mismatched++;
                $display("FAIL R5 phase_sel moved outside window got %h exp %h",
                         phase_sel, prev_p);
            end
            prev_p = phase_sel;
            // R3: count observed strobes per period
            for (int i = 0; i < NO; i++) begin
                if (!m_run || m_pos == 0) hits[i] = 0;
                if (m_run && strobe[i] === 1'b1) hits[i]++;
                if (m_run && m_pos == PR - 1) begin
                    compared++;
                    if (hits[i] != 1 || strobe[i] !== 1'b0) begin
                        mismatched++;
                        $display("FAIL R3 output %0d strobes in period got %0d exp 1",
                                 i, hits[i]);
                    end
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reset();
        compared++;
        if (strobe !== '0 || phase_sel !== '0) begin
            mismatched++;
            $display("FAIL R1 after reset strobe=%h sel=%h exp 0/0", strobe, phase_sel);
        end
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        check_reset();
        cycles(4);
        enable = 1'b1;
        cycles(PR * 10);
        // enable gap inside a period (R2)
        cycles(5);
        enable = 1'b0;
        cycles(7);
        enable = 1'b1;
        cycles(PR * 4 + 3);
        // seed loads (R7)
        sel_tag = "R7";
        seed_val = 32'h1234_5678;
        seed_load = 1'b1;
        cycles(1);
        seed_load = 1'b0;
        cycles(PR * 5);
        seed_val = 32'h0;
        seed_load = 1'b1;
        cycles(1);
        seed_load = 1'b0;
        cycles(PR * 5 - 2);
        seed_val = 32'hDEAD_BEEF;
        seed_load = 1'b1;
        cycles(PR + 2);
        seed_load = 1'b0;
        cycles(PR * 5);
        sel_tag = "R6";
        // reset during operation (R1)
        cycles(9);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        check_reset();
        cycles(PR * 20);
        enable = 1'b0;
        cycles(PR);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule